// File: doc/BRIEF.md
# Two-Dimensional Frame Buffer Address Walker

This block produces the stream of read requests that pulls a frame buffer out of memory for a video output port. Software sets a base byte address, a word count per row with a signed byte step between words, and a row count with a signed byte step applied after the last word of a row. A start pulse, given while the enable input is high, launches the walk. The block offers one address at a time and moves on only when the consumer accepts it with a valid/ready handshake. Each request carries a word-size flag and marks the last word of a row and the last word of a frame.

In one-shot mode the walk ends after the last word of the frame. In autobuffer mode it jumps back to the base address and repeats the frame with no software action. Dropping the enable input stops the walk cleanly: the word already on offer is still handed over, and then the block goes quiet.

The control is a two-state machine. In `AGU_IDLE` no request is offered. The *launch* transition takes `AGU_IDLE` to `AGU_RUN` on an accepted start pulse. In `AGU_RUN` a request is always offered. *Wrap* keeps `AGU_RUN` across a frame boundary in autobuffer mode. *Finish* returns to `AGU_IDLE` after the last word of a one-shot frame. *Halt* returns to `AGU_IDLE` after any accepted word while enable is low.

Top module: `frame_addr_walker`

## Requirements
- R1: While reset is asserted and after it is released, `req_valid`, `req_row_end` and `req_frame_end` are 0 until a start is accepted.
- R2: A start pulse seen with `ctl_enable` high and both counts nonzero in `AGU_IDLE` raises `req_valid` on the next cycle. `req_addr` then equals `cfg_base`, and `req_wide` equals the `cfg_wide` value sampled with the start (1 = 16-bit words, 0 = 8-bit words).
- R3: After an accepted word that is not the last of its row, the next address equals the previous address plus the sign-extended inner step (`cfg_x_step`, two's complement bytes), modulo 2^ADDR_W.
- R4: After an accepted last word of a row that is not the last row, the next address equals the previous address plus the sign-extended outer step (`cfg_y_step`), and the row word count starts again.
- R5: `req_row_end` is 1 exactly while the offered word is word number `cfg_x_count` of its row. `req_frame_end` is 1 exactly while the offered word is also in row number `cfg_y_count`.
- R6: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr`, `req_row_end` and `req_frame_end` hold their values into the next cycle.
- R7: In one-shot mode (`cfg_autobuf` = 0 at start), `req_valid` is 0 on the cycle after the last word of the frame is accepted.
- R8: In autobuffer mode (`cfg_autobuf` = 1 at start), with enable high, the cycle after the last word of the frame is accepted offers `cfg_base` again, and the walk repeats the same pattern.
- R9: When `ctl_enable` is 0, the word already on offer stays offered until it is accepted. On the cycle after that acceptance, `req_valid` is 0.
- R10: A start pulse has no effect while `ctl_enable` is 0, while either count is 0, or while the walk is running. Configuration inputs changed after an accepted start do not alter the running walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Run permission; low stops at the next accepted word |
| ctl_start | input | 1 | Start pulse; latches the configuration and loads the counters |
| cfg_autobuf | input | 1 | 1 = repeat the frame, 0 = single frame |
| cfg_wide | input | 1 | Word size: 1 = 16-bit, 0 = 8-bit |
| cfg_base | input | ADDR_W | Frame base byte address |
| cfg_x_count | input | CNT_W | Words per row |
| cfg_x_step | input | CNT_W | Signed byte step between words in a row |
| cfg_y_count | input | CNT_W | Rows per frame |
| cfg_y_step | input | CNT_W | Signed byte step after the last word of a row |
| req_ready | input | 1 | Consumer accepts the offered word |
| req_valid | output | 1 | A read request is offered |
| req_addr | output | ADDR_W | Byte address of the offered word |
| req_wide | output | 1 | Word size of the offered word |
| req_row_end | output | 1 | Offered word is the last of its row |
| req_frame_end | output | 1 | Offered word is the last of the frame |

## Verification
The properties assume three things about the inputs: `ADDR_W` is wider than `CNT_W`, the counts seen with an accepted start are nonzero, and `ctl_enable` only drops to end a walk. They place no condition on `req_ready`. Under those assumptions, the hold check and the stop checks cover every stall pattern. The stimulus drives `req_ready` from a shift-register sequence, so stalls come in streaks of varying length. It launches walks only with nonzero counts, and it keeps enable high until the last planned word has been taken. Once each walk is running, the stimulus overwrites the configuration inputs with unrelated values and pulses start again, which shows that the latched copies are the only ones used.

// File: rtl/faw_pkg.sv
package faw_pkg;

    typedef enum logic {
        AGU_IDLE = 1'b0,
        AGU_RUN  = 1'b1
    } agu_state_e;

    localparam int unsigned AXIS_X = 0;
    localparam int unsigned AXIS_Y = 1;
    localparam int unsigned N_AXES = 2;

endpackage

// File: rtl/faw_axis_counter.sv
module faw_axis_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_last
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] period_q;
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            count_q  <= '0;
        end else if (load) begin
            period_q <= load_val;
            count_q  <= load_val;
        end else if (dec) begin
            count_q <= (count_q == ONE) ? period_q : count_q - ONE;
        end
    end

    assign is_last = (count_q == ONE);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !load && !is_last |=> count_q == $past(count_q) - ONE);

    // R4
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !load && is_last |=> count_q == $past(period_q));

endmodule

// File: rtl/faw_addr_unit.sv
module faw_addr_unit #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  x_step,
    input  logic [CNT_W-1:0]  y_step,
    input  logic              adv,
    input  logic              at_row_end,
    input  logic              at_frame_end,
    output logic [ADDR_W-1:0] addr
);

    localparam int unsigned EXT = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] xs_ext_q;
    logic [ADDR_W-1:0] ys_ext_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        if (at_frame_end) begin
            addr_d = base_q;
        end else if (at_row_end) begin
            addr_d = addr_q + ys_ext_q;
        end else begin
            addr_d = addr_q + xs_ext_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            xs_ext_q <= '0;
            ys_ext_q <= '0;
            addr_q   <= '0;
        end else if (load) begin
            base_q   <= base;
            xs_ext_q <= {{EXT{x_step[CNT_W-1]}}, x_step};
            ys_ext_q <= {{EXT{y_step[CNT_W-1]}}, y_step};
            addr_q   <= base;
        end else if (adv) begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;

    // R3
    inner_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load && !at_row_end |=> addr == $past(addr) + $past(xs_ext_q));

    // R4
    outer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load && at_row_end && !at_frame_end |=> addr == $past(addr) + $past(ys_ext_q));

endmodule

// File: rtl/frame_addr_walker.sv
module frame_addr_walker
    import faw_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_enable,
    input  logic              ctl_start,
    input  logic              cfg_autobuf,
    input  logic              cfg_wide,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_x_count,
    input  logic [CNT_W-1:0]  cfg_x_step,
    input  logic [CNT_W-1:0]  cfg_y_count,
    input  logic [CNT_W-1:0]  cfg_y_step,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_wide,
    output logic              req_row_end,
    output logic              req_frame_end
);

    agu_state_e state_q, state_d;

    logic             auto_q;
    logic             wide_q;
    logic             launch;
    logic             xfer;
    logic             row_last;
    logic             frame_last;
    logic [N_AXES-1:0] cnt_dec;
    logic [N_AXES-1:0] cnt_last;
    logic [CNT_W-1:0] cnt_init [N_AXES];

    assign launch = (state_q == AGU_IDLE) && ctl_start && ctl_enable
                    && (cfg_x_count != '0) && (cfg_y_count != '0);
    assign xfer       = req_valid && req_ready;
    assign row_last   = cnt_last[AXIS_X];
    assign frame_last = cnt_last[AXIS_X] && cnt_last[AXIS_Y];

    assign cnt_init[AXIS_X] = cfg_x_count;
    assign cnt_init[AXIS_Y] = cfg_y_count;
    assign cnt_dec[AXIS_X]  = xfer;
    assign cnt_dec[AXIS_Y]  = xfer && row_last;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AGU_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: launch, finish, halt, wrap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AGU_IDLE: begin
                if (launch) begin
                    state_d = AGU_RUN;
                end
            end
            AGU_RUN: begin
                if (xfer && !ctl_enable) begin
                    state_d = AGU_IDLE;
                end else if (xfer && frame_last && !auto_q) begin
                    state_d = AGU_IDLE;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        req_valid     = 1'b0;
        req_row_end   = 1'b0;
        req_frame_end = 1'b0;
        unique case (state_q)
            AGU_IDLE: begin
                req_valid = 1'b0;
            end
            AGU_RUN: begin
                req_valid     = 1'b1;
                req_row_end   = row_last;
                req_frame_end = frame_last;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q <= 1'b0;
            wide_q <= 1'b0;
        end else if (launch) begin
            auto_q <= cfg_autobuf;
            wide_q <= cfg_wide;
        end
    end

    assign req_wide = wide_q;

    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        faw_axis_counter #(
            .W(CNT_W)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (launch),
            .load_val (cnt_init[g]),
            .dec      (cnt_dec[g]),
            .is_last  (cnt_last[g])
        );
    end

    faw_addr_unit #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (launch),
        .base         (cfg_base),
        .x_step       (cfg_x_step),
        .y_step       (cfg_y_step),
        .adv          (xfer),
        .at_row_end   (row_last),
        .at_frame_end (frame_last),
        .addr         (req_addr)
    );

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
            && $stable(req_row_end) && $stable(req_frame_end));

    // R7
    oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && req_frame_end && !auto_q |=> !req_valid);

    // R8
    auto_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && req_frame_end && auto_q && ctl_enable |=> req_valid);

    // R9
    halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && !ctl_enable |=> !req_valid);

endmodule

// File: tb/frame_addr_walker_test.sv
module frame_addr_walker_test;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_enable = 1'b0;
    logic              ctl_start = 1'b0;
    logic              cfg_autobuf = 1'b0;
    logic              cfg_wide = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [CNT_W-1:0]  cfg_x_count = '0;
    logic [CNT_W-1:0]  cfg_x_step = '0;
    logic [CNT_W-1:0]  cfg_y_count = '0;
    logic [CNT_W-1:0]  cfg_y_step = '0;
    logic              req_ready = 1'b0;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic              req_wide;
    logic              req_row_end;
    logic              req_frame_end;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] lfsr = 8'hA5;

    frame_addr_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_start(ctl_start),
        .cfg_autobuf(cfg_autobuf), .cfg_wide(cfg_wide), .cfg_base(cfg_base),
        .cfg_x_count(cfg_x_count), .cfg_x_step(cfg_x_step),
        .cfg_y_count(cfg_y_count), .cfg_y_step(cfg_y_step),
        .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
        .req_wide(req_wide), .req_row_end(req_row_end), .req_frame_end(req_frame_end)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    endtask

    // Walks one configuration; the model is pure arithmetic on the word index.
    task automatic run_walk(input logic [31:0] base, input int xc, input int xs,
                            input int yc, input int ys, input bit wide,
                            input bit autob, input int frames, input bit poke);
        int n = 0;
        int guard = 0;
        int total = xc * yc * frames;
        int pitch = (xc - 1) * xs + ys;
        cfg_base    = base;
        cfg_x_count = CNT_W'(xc);
        cfg_x_step  = CNT_W'(xs);
        cfg_y_count = CNT_W'(yc);
        cfg_y_step  = CNT_W'(ys);
        cfg_wide    = wide;
        cfg_autobuf = autob;
        ctl_enable  = 1'b1;
        ctl_start   = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
        // R10: scribble over configuration after launch
        cfg_base    = ~base;
        cfg_x_count = 16'd7;
        cfg_y_count = 16'd5;
        cfg_x_step  = 16'd3;
        cfg_y_step  = 16'd3;
        cfg_wide    = ~wide;
        cfg_autobuf = ~autob;
        while (n < total && guard < 2000) begin
            int wn = n % (xc * yc);
            int i = wn % xc;
            int j = wn / xc;
            logic [31:0] exp_addr = base + 32'(j * pitch) + 32'(i * xs);
            bit exp_row = (i == xc - 1);
            bit exp_frm = exp_row && (j == yc - 1);
            step_lfsr();
            req_ready = lfsr[0] | lfsr[1];
            ctl_start = poke && (n == 1);
            chk(req_valid == 1'b1, "R2/R8 valid", 32'(req_valid), 32'd1);
            chk(req_addr == exp_addr, "R3/R4/R8/R10 addr", req_addr, exp_addr);
            chk(req_row_end == exp_row, "R5 row_end", 32'(req_row_end), 32'(exp_row));
            chk(req_frame_end == exp_frm, "R5 frame_end", 32'(req_frame_end), 32'(exp_frm));
            chk(req_wide == wide, "R2 wide", 32'(req_wide), 32'(wide));
            if (req_ready) n++;
            @(negedge clk);
            guard++;
        end
        ctl_start = 1'b0;
        req_ready = 1'b0;
        if (!autob) begin
            chk(req_valid == 1'b0, "R7 idle after frame", 32'(req_valid), 32'd0);
        end else begin
            ctl_enable = 1'b0;
            chk(req_valid == 1'b1 && req_addr == base, "R8 restart at base", req_addr, base);
            @(negedge clk);
            chk(req_valid == 1'b1, "R9 offered word held", 32'(req_valid), 32'd1);
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            chk(req_valid == 1'b0, "R9 stopped", 32'(req_valid), 32'd0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(req_valid == 1'b0 && req_row_end == 1'b0 && req_frame_end == 1'b0,
            "R1 reset outputs", {29'd0, req_valid, req_row_end, req_frame_end}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R1 after reset", 32'(req_valid), 32'd0);

        // R10: start with enable low
        cfg_x_count = 16'd2; cfg_y_count = 16'd2; ctl_enable = 1'b0; ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
        chk(req_valid == 1'b0, "R10 start while disabled", 32'(req_valid), 32'd0);
        // R10: zero counts
        ctl_enable = 1'b1; cfg_x_count = 16'd0; ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
        chk(req_valid == 1'b0, "R10 zero row count", 32'(req_valid), 32'd0);
        cfg_x_count = 16'd3; cfg_y_count = 16'd0; ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
        chk(req_valid == 1'b0, "R10 zero frame count", 32'(req_valid), 32'd0);

        // Sweep of small shapes and steps
        for (int xc = 1; xc <= 3; xc++) begin
            for (int yc = 1; yc <= 3; yc++) begin
                for (int k = 0; k < 3; k++) begin
                    int xs = (k == 0) ? 2 : ((k == 1) ? 1 : -2);
                    int ys = (k == 0) ? 2 : ((k == 1) ? -5 : 100);
                    bit autob = ((xc + yc + k) % 2) == 1;
                    run_walk(32'h1000 * xc + 32'(yc * 16 + k), xc, xs, yc, ys,
                             k[0], autob, autob ? 2 : 1, k == 1);
                end
            end
        end
        // Base of zero, 16-bit words, wider rows
        run_walk(32'h0, 16, 2, 4, 2, 1'b1, 1'b1, 2, 1'b1);
        // Address wrap past the top of the space
        run_walk(32'hFFFF_FFFC, 4, 2, 2, -6, 1'b0, 1'b0, 1, 1'b0);
        // Larger one-shot frame with an outer step that skips a stride
        run_walk(32'h0002_0000, 64, 2, 4, 130, 1'b1, 1'b0, 1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule